// File: doc/BRIEF.md
# Key-Protected Control Register Partitions

This block holds a bank of memory-mapped control registers split into several equal partitions. Each partition has its own write lock. A partition leaves reset locked. While it is locked, any write to its control registers is thrown away without notice. Software opens a partition by writing one magic value to a first kick register and then a second magic value to a second kick register. One such unlock opens every control register in that partition and leaves the other partitions locked.

The register contents are brought out on a flat output bus, so that downstream logic can use them directly. An example is the interface-mode field of a MAC port. A control register always reads back its stored value. The first kick register reads back the lock status of its partition and never returns a key. The bus is a plain slave: address, write enable and write data, with read data taken combinationally from the current address.

Top module: `kpart_ctrl`

## Requirements
- R1: After reset, every partition is locked and its status reads 0. Control register 0 of each partition holds 0x1, whose bits [1:0] = 2'b01 are the RMII mode code. All other control registers hold 0.
- R2: While a partition is locked, a write to any of its control registers leaves the stored value unchanged.
- R3: Writing 0x68EF3490 to offset 0x1008 (first kick) and then 0xD172BC5A to offset 0x100C (second kick) unlocks the partition. Extra correct first-kick writes before the second kick are allowed.
- R4: A correct second-kick write that has no correct first-kick write pending does not unlock the partition.
- R5: A wrong value written to either kick register returns the partition to fully locked, so a new first kick is needed. This also applies when the partition is unlocked. Correct kick values written while unlocked keep it unlocked.
- R6: Each partition spans 0x4000 bytes and is selected by address bits [15:14]. Its lock state is independent of the other partitions.
- R7: A read of offset 0x1008 returns the partition's lock status in bit 0 (1 = unlocked), with all other bits 0.
- R8: A read of offset 0x100C returns 0. The kick registers never return a key value.
- R9: One unlock enables writes to all control registers of the partition. These are at offsets 4*i for i below NUM_REGS, and register i of partition p drives ctrl_regs_o bits [(p*NUM_REGS+i)*32 +: 32].
- R10: A read of a control register returns its stored value, whether the partition is locked or unlocked.
- R11: Writing the RGMII code 2'b10 to bits [1:0] of control register 0 changes the mode on ctrl_regs_o only after that partition has been unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | Byte address: partition index in [15:14], offset in [13:0] |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current address |
| ctrl_regs_o | output | 512 | All control registers of all partitions, concatenated |

## Verification
A lock state machine stuck in the wrong state shows up on the status bit at offset 0x1008 in the cycle after the kick write that caused it. It also shows up on the next control-register write, which then either lands on ctrl_regs_o when it should not or fails to land when it should. A decode error that reaches a neighbouring partition shows up as a status change in that partition, which stays locked in every correct run. Gating errors can be seen one clock after the write edge, both on rd_data and on the output bus.

// File: rtl/kpart_pkg.sv
package kpart_pkg;
   typedef enum logic [1:0] {
      LK_SHUT = 2'd0,
      LK_HALF = 2'd1,
      LK_OPEN = 2'd2
   } lk_state_t;

   localparam logic [1:0] MODE_RMII  = 2'b01;
   localparam logic [1:0] MODE_RGMII = 2'b10;
endpackage

// File: rtl/kpart_lock.sv
module kpart_lock
   import kpart_pkg::*;
#(
   parameter int              DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY0 = 32'h68EF3490,
   parameter logic [DATA_W-1:0] KEY1 = 32'hD172BC5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kick0_wr,
   input  logic              kick1_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              unlocked_o
);
   lk_state_t state, nxt;

   always_comb begin
      nxt = state;
      if (kick0_wr) begin
         if (wdata != KEY0)        nxt = LK_SHUT;
         else if (state != LK_OPEN) nxt = LK_HALF;
      end else if (kick1_wr) begin
         if (wdata != KEY1)         nxt = LK_SHUT;
         else if (state == LK_HALF) nxt = LK_OPEN;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= LK_SHUT;
      else        state <= nxt;
   end

   assign unlocked_o = (state == LK_OPEN);

   assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (kick1_wr && !kick0_wr && wdata == KEY1 && state == LK_HALF) |=> unlocked_o);

   assert_kick1_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_SHUT) |=> !unlocked_o);

   assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((kick0_wr && wdata != KEY0) || (!kick0_wr && kick1_wr && wdata != KEY1))
      |=> (state == LK_SHUT));
endmodule

// File: rtl/kpart_bank.sv
module kpart_bank #(
   parameter int                DATA_W   = 32,
   parameter int                NUM_REGS = 4,
   parameter logic [DATA_W-1:0] RESET0   = 32'h1,
   localparam int               IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       unlocked_i,
   input  logic                       wr_i,
   input  logic [IDX_W-1:0]           idx_i,
   input  logic [DATA_W-1:0]          wdata_i,
   output logic [DATA_W-1:0]          rdata_o,
   output logic [NUM_REGS*DATA_W-1:0] regs_o
);
   logic [DATA_W-1:0] store [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [DATA_W-1:0] RST_V = (i == 0) ? RESET0 : '0;
      always_ff @(posedge clk) begin
         if (!rst_n)
            store[i] <= RST_V;
         else if (unlocked_i && wr_i && idx_i == IDX_W'(i))
            store[i] <= wdata_i;
      end
      assign regs_o[i*DATA_W +: DATA_W] = store[i];

      assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !unlocked_i |=> $stable(store[i]));
   end

   assign rdata_o = store[idx_i];
endmodule

// File: rtl/kpart_ctrl.sv
module kpart_ctrl
   import kpart_pkg::*;
#(
   parameter int  NUM_PART    = 4,
   parameter int  NUM_REGS    = 4,
   parameter int  DATA_W      = 32,
   parameter int  SPAN_W      = 14,
   parameter logic [DATA_W-1:0] KEY0       = 32'h68EF3490,
   parameter logic [DATA_W-1:0] KEY1       = 32'hD172BC5A,
   parameter logic [SPAN_W-1:0] KICK0_OFS  = 14'h1008,
   parameter logic [SPAN_W-1:0] KICK1_OFS  = 14'h100C,
   parameter logic [DATA_W-1:0] REG0_RESET = {{(DATA_W-2){1'b0}}, MODE_RMII},
   localparam int PART_W = $clog2(NUM_PART),
   localparam int ADDR_W = SPAN_W + PART_W,
   localparam int IDX_W  = $clog2(NUM_REGS),
   localparam int OUT_W  = NUM_PART * NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [OUT_W-1:0]  ctrl_regs_o
);
   if (NUM_PART < 2 || (1 << PART_W) != NUM_PART) begin : g_bad_part
      $error("NUM_PART must be a power of two, at least 2");
   end
   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (SPAN_W < IDX_W + 3) begin : g_bad_span
      $error("SPAN_W too small for NUM_REGS");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must hold the mode field");
   end

   logic [PART_W-1:0] part;
   logic [SPAN_W-1:0] ofs;
   logic              is_k0, is_k1, is_reg;
   logic [IDX_W-1:0]  idx;

   assign part   = addr[ADDR_W-1 -: PART_W];
   assign ofs    = addr[SPAN_W-1:0];
   assign is_k0  = (ofs == KICK0_OFS);
   assign is_k1  = (ofs == KICK1_OFS);
   assign is_reg = (ofs[1:0] == 2'b00) && (ofs[SPAN_W-1:2+IDX_W] == '0);
   assign idx    = ofs[2+IDX_W-1:2];

   logic              unlocked [NUM_PART];
   logic [DATA_W-1:0] rdat     [NUM_PART];

   for (genvar p = 0; p < NUM_PART; p++) begin : g_part
      logic sel;
      assign sel = wr_en && (part == PART_W'(p));

      kpart_lock #(.DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1)) u_lock (
         .clk        (clk),
         .rst_n      (rst_n),
         .kick0_wr   (sel && is_k0),
         .kick1_wr   (sel && is_k1),
         .wdata      (wr_data),
         .unlocked_o (unlocked[p])
      );

      kpart_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .RESET0(REG0_RESET)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .unlocked_i (unlocked[p]),
         .wr_i       (sel && is_reg),
         .idx_i      (idx),
         .wdata_i    (wr_data),
         .rdata_o    (rdat[p]),
         .regs_o     (ctrl_regs_o[p*NUM_REGS*DATA_W +: NUM_REGS*DATA_W])
      );

      assert_other_part_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && part != PART_W'(p)) |=> $stable(unlocked[p]));
   end

   always_comb begin
      rd_data = '0;
      if (is_k0)       rd_data[0] = unlocked[part];
      else if (is_reg) rd_data    = rdat[part];
   end
endmodule

// File: tb/kpart_ctrl_tb.sv
module kpart_ctrl_tb;
   localparam logic [31:0] K0 = 32'h68EF3490;
   localparam logic [31:0] K1 = 32'hD172BC5A;

   typedef struct packed {
      logic        rd;
      logic [15:0] a;
      logic [31:0] d;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 16'h0000, 32'h1,      8'd1},  // R1 mode default RMII
      '{1'b1, 16'h0004, 32'h0,      8'd1},  // R1
      '{1'b1, 16'h1008, 32'h0,      8'd7},  // R7 status locked
      '{1'b0, 16'h0000, 32'h2,      8'd2},  // write while locked
      '{1'b1, 16'h0000, 32'h1,      8'd2},  // R2 dropped
      '{1'b0, 16'h1008, K0,         8'd3},
      '{1'b1, 16'h1008, 32'h0,      8'd3},  // R3 half way still locked
      '{1'b0, 16'h100C, K1,         8'd3},
      '{1'b1, 16'h1008, 32'h1,      8'd3},  // R3 unlocked
      '{1'b1, 16'h100C, 32'h0,      8'd8},  // R8 no key readback
      '{1'b0, 16'h0000, 32'h2,      8'd11},
      '{1'b1, 16'h0000, 32'h2,      8'd11}, // R11 RGMII after unlock
      '{1'b0, 16'h000C, 32'h1234,   8'd9},
      '{1'b1, 16'h000C, 32'h1234,   8'd9},  // R9 whole bank open
      '{1'b1, 16'h5008, 32'h0,      8'd6},  // R6 partition 1 still locked
      '{1'b0, 16'h4004, 32'hABCD,   8'd6},
      '{1'b1, 16'h4004, 32'h0,      8'd6},  // R6 partition 1 write dropped
      '{1'b0, 16'h1008, 32'h5,      8'd5},  // wrong key while open
      '{1'b1, 16'h1008, 32'h0,      8'd5},  // R5 relocked
      '{1'b0, 16'h0000, 32'h3,      8'd2},
      '{1'b1, 16'h0000, 32'h2,      8'd10}, // R10 stored value while locked
      '{1'b1, 16'h000C, 32'h1234,   8'd10}  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [511:0] ctrl_regs_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   kpart_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (addr),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .ctrl_regs_o (ctrl_regs_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input string req, input logic [15:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      check(req, rd_data, exp);
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].rd) do_rd($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].a, VECS[i].d);
         else            do_wr(VECS[i].a, VECS[i].d);
      end

      // R11 / R9: port view of partition 0
      check("R11 port mode p0", ctrl_regs_o[31:0], 32'h2);
      check("R9 port p0 reg3", ctrl_regs_o[3*32 +: 32], 32'h1234);
      check("R6 port p1 reg1", ctrl_regs_o[5*32 +: 32], 32'h0);

      // R4: second kick alone, partition 2
      do_wr(16'h900C, K1);
      do_rd("R4 kick1 alone", 16'h9008, 32'h0);
      do_wr(16'h8000, 32'h2);
      check("R11 locked mode p2", ctrl_regs_o[8*32 +: 32], 32'h1);
      // R5: wrong second kick clears the first step
      do_wr(16'h9008, K0);
      do_wr(16'h900C, 32'h0);
      do_wr(16'h900C, K1);
      do_rd("R5 bad kick1 resets", 16'h9008, 32'h0);
      // R3: repeated first kick then second kick
      do_wr(16'h9008, K0);
      do_wr(16'h9008, K0);
      do_wr(16'h900C, K1);
      do_rd("R3 repeated kick0", 16'h9008, 32'h1);
      do_wr(16'h9008, K0);
      do_rd("R5 good kick0 keeps open", 16'h9008, 32'h1);
      do_wr(16'h900C, K1);
      do_rd("R5 good kick1 keeps open", 16'h9008, 32'h1);
      do_wr(16'h8000, 32'h2);
      check("R11 mode p2 after unlock", ctrl_regs_o[8*32 +: 32], 32'h2);
      do_rd("R6 p0 unaffected", 16'h1008, 32'h0);

      // R1: reset again
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      do_rd("R1 p2 status", 16'h9008, 32'h0);
      do_rd("R1 p2 mode", 16'h8000, 32'h1);
      do_rd("R1 p0 reg3", 16'h000C, 32'h0);
      check("R1 port p0 mode", ctrl_regs_o[31:0], 32'h1);

      done = 1'b1;
      summary();
   end
endmodule